// File: doc/BRIEF.md
# NAND Flash Target Command Interface

This block models the device side of a small-page NAND flash part. A host drives an 8-bit input bus together with command-latch and address-latch qualifiers, an active-low chip enable, an active-low write protect and two single-cycle strobes, one for writing and one for reading. The block decodes command bytes and collects address cycles. It serves array reads, identification, status, page program, block erase and a soft reset against an internal byte array. An active-low ready/busy output reports when an array operation is running.

Geometry is set by parameters: `COL_W` column bits (page = 2^COL_W bytes), `ROW_W` row bits (2^ROW_W pages) and `PB_W` page bits per block. An address is one column cycle followed by two row cycles, least significant first; erase takes two row cycles only. Program merges a page buffer into the stored page by bitwise AND, so cells only move from 1 to 0. Erase sets a whole block back to 0xFF. A walker applies either change one byte per cycle while the block reports busy for `BUSY_CYCLES` cycles.

Controller states: `ST_IDLE` (no sequence open), `ST_RD_ADDR` (0x00 received, collecting address), `ST_RD_DATA` (array streaming), `ST_PG_ADDR` (0x80 received, collecting address), `ST_PG_DATA` (filling page buffer), `ST_ER_ADDR` (0x60 received, collecting row) and `ST_BUSY` (array operation running). Transitions: 0x00 → `ST_RD_ADDR`, third address cycle → `ST_RD_DATA`; 0x80 → `ST_PG_ADDR`, third address cycle → `ST_PG_DATA`, 0x10 → `ST_BUSY` (or `ST_IDLE` when protected); 0x60 → `ST_ER_ADDR`, 0xD0 → `ST_BUSY` (or `ST_IDLE` when protected); 0x90, 0x70 and 0xFF → `ST_IDLE`; the busy counter reaching zero → `ST_IDLE`.

Top module: `nand_target`

## Requirements
- R1: A write strobe with `ce_n` low is a command byte when `cle`=1 and `ale`=0, an address byte when `ale`=1 and `cle`=0, and a data byte when both are 0. With `ce_n` high, or with `cle` and `ale` both high, the write strobe has no effect; with `ce_n` high a read strobe has no effect.
- R2: Command 0x90 makes four bytes readable in this order: `MFR_CODE`, `DEV_CODE`, 0x5A, 0xC0. Each read strobe moves to the next byte; after the fourth, `io_out` is 0x00.
- R3: Command 0x70 makes one byte readable, the status: bit 7 = `wp_n` (1 = not protected), bit 6 = 1 when ready, bit 0 = error flag, all other bits 0. After one read strobe `io_out` is 0x00.
- R4: Command 0x00 plus column, row-low and row-high cycles shows the byte at page row, column col on `io_out`. Each read strobe advances one byte, running past the page end into the next page.
- R5: Command 0x80 fills the page buffer with 0xFF and resets its pointer. The three address cycles pick the page by its row (column is ignored), and the data bytes that follow fill the buffer from index 0; bytes beyond one page are dropped. Command 0x10 in the data phase ANDs the buffer into that page.
- R6: Command 0x60, two row cycles (low byte first) and 0xD0 set every byte of the block that contains the row to 0xFF. The block byte address is the row shifted left by `COL_W` with its low `PB_W` row bits cleared. Other blocks keep their contents.
- R7: After an accepted program or erase confirm, `rb_n` is low for exactly `BUSY_CYCLES` cycles, starting with the cycle after the confirm. Status bit 6 reads 0 throughout.
- R8: While busy, only command 0x70 is accepted; every other write strobe is ignored.
- R9: A confirm (0x10 or 0xD0) arriving while `wp_n` is low leaves the array unchanged and does not go busy. It sets the status error bit.
- R10: Command 0xFF closes any sequence, clears the collected address, buffer pointer and readable data (`io_out` becomes 0x00) and clears the error bit. Status bit 7 still follows `wp_n`.
- R11: Opcodes other than 0x00, 0x10, 0x60, 0x70, 0x80, 0x90, 0xD0 and 0xFF change nothing. A 0x10 or 0xD0 outside its own sequence also changes nothing.
- R12: When the write and read strobes come in the same cycle, the write is processed and the read is ignored.
- R13: After hardware reset every array byte is 0xFF, `rb_n` is 1 and `io_out` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Marks a written byte as a command |
| ale | input | 1 | Marks a written byte as an address cycle |
| wp_n | input | 1 | Write protect, active low |
| wr_stb | input | 1 | One-cycle write strobe; latches `io_in` |
| rd_stb | input | 1 | One-cycle read strobe; advances the output byte |
| io_in | input | 8 | Command, address or data byte from the host |
| io_out | output | 8 | Byte currently readable by the host |
| rb_n | output | 1 | Ready/busy, low while an array operation runs |

## Verification
The write strobe and the read strobe can fall in the same cycle. The bench provokes this right after a 0x90 by raising both strobes together with a data byte that is ignored in the idle state. It judges the result by the ID byte: the manufacturer code must still be shown, and the device code must follow only after a later lone read strobe. A second overlap comes from a status command issued while the array walker is rewriting a page. The status byte must read with bit 6 clear, and a 0x90 sent during the same busy window must leave that byte in place.

// File: rtl/nand_target_pkg.sv
package nand_target_pkg;

    localparam logic [7:0] OP_READ     = 8'h00;
    localparam logic [7:0] OP_PROG_GO  = 8'h10;
    localparam logic [7:0] OP_ERASE    = 8'h60;
    localparam logic [7:0] OP_STATUS   = 8'h70;
    localparam logic [7:0] OP_PROG     = 8'h80;
    localparam logic [7:0] OP_ID       = 8'h90;
    localparam logic [7:0] OP_ERASE_GO = 8'hD0;
    localparam logic [7:0] OP_RESET    = 8'hFF;

    localparam logic [7:0] ID_FILLER    = 8'h5A;
    localparam logic [7:0] ID_SMALLPAGE = 8'hC0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ADDR,
        ST_RD_DATA,
        ST_PG_ADDR,
        ST_PG_DATA,
        ST_ER_ADDR,
        ST_BUSY
    } ctl_state_e;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_ARRAY,
        SRC_ID,
        SRC_STAT
    } out_src_e;

    typedef enum logic {
        JOB_PROG,
        JOB_ERASE
    } job_e;

endpackage

// File: rtl/nand_target_store.sv
module nand_target_store
    import nand_target_pkg::*;
#(
    parameter int COL_W = 4,
    parameter int ROW_W = 5,
    parameter int PB_W  = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   buf_clr,
    input  logic                   buf_we,
    input  logic [COL_W-1:0]       buf_idx,
    input  logic [7:0]             buf_data,
    input  logic                   job_go,
    input  job_e                   job_kind,
    input  logic [COL_W+ROW_W-1:0] job_base,
    input  logic [COL_W+ROW_W-1:0] rd_addr,
    output logic [7:0]             rd_data
);

    localparam int MEM_W  = COL_W + ROW_W;
    localparam int MEM_B  = 1 << MEM_W;
    localparam int PAGE_B = 1 << COL_W;
    localparam int CNT_W  = COL_W + PB_W;
    localparam int BLK_B  = 1 << CNT_W;

    logic [7:0]       mem  [MEM_B];
    logic [7:0]       pbuf [PAGE_B];
    logic             walk_q;
    job_e             kind_q;
    logic [MEM_W-1:0] base_q;
    logic [CNT_W-1:0] cnt_q;
    logic [MEM_W-1:0] walk_addr;
    logic [CNT_W-1:0] walk_last;
    logic [7:0]       walk_byte;

    always_comb begin
        walk_addr = base_q + MEM_W'(cnt_q);
        walk_last = (kind_q == JOB_PROG) ? CNT_W'(PAGE_B - 1) : CNT_W'(BLK_B - 1);
        walk_byte = (kind_q == JOB_PROG) ? (mem[walk_addr] & pbuf[cnt_q[COL_W-1:0]]) : 8'hFF;
        rd_data   = mem[rd_addr];
    end

    // Page buffer: cleared to all ones at program setup, filled by data bytes.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < PAGE_B; i++) pbuf[i] <= 8'hFF;
        end else if (buf_clr) begin
            for (int i = 0; i < PAGE_B; i++) pbuf[i] <= 8'hFF;
        end else if (buf_we) begin
            pbuf[buf_idx] <= buf_data;
        end
    end

    // Walker: one array byte per cycle for program (page) or erase (block).
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_B; i++) mem[i] <= 8'hFF;
            walk_q <= 1'b0;
            kind_q <= JOB_PROG;
            base_q <= '0;
            cnt_q  <= '0;
        end else if (job_go) begin
            walk_q <= 1'b1;
            kind_q <= job_kind;
            base_q <= job_base;
            cnt_q  <= '0;
        end else if (walk_q) begin
            mem[walk_addr] <= walk_byte;
            cnt_q          <= cnt_q + CNT_W'(1);
            if (cnt_q == walk_last) walk_q <= 1'b0;
        end
    end

    // R5
    walk_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        job_go |=> walk_q);

    // R8
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_q |-> !job_go);

endmodule

// File: rtl/nand_target_ctrl.sv
module nand_target_ctrl
    import nand_target_pkg::*;
#(
    parameter int         COL_W       = 4,
    parameter int         ROW_W       = 5,
    parameter int         PB_W        = 2,
    parameter int         BUSY_CYCLES = 80,
    parameter logic [7:0] MFR_CODE    = 8'hEC,
    parameter logic [7:0] DEV_CODE    = 8'h73
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ce_n,
    input  logic                   cle,
    input  logic                   ale,
    input  logic                   wp_n,
    input  logic                   wr_stb,
    input  logic                   rd_stb,
    input  logic [7:0]             io_in,
    output logic [7:0]             io_out,
    output logic                   rb_n,
    output logic                   buf_clr,
    output logic                   buf_we,
    output logic [COL_W-1:0]       buf_idx,
    output logic [7:0]             buf_data,
    output logic                   job_go,
    output job_e                   job_kind,
    output logic [COL_W+ROW_W-1:0] job_base,
    output logic [COL_W+ROW_W-1:0] rd_addr,
    input  logic [7:0]             rd_data
);

    localparam int MEM_W = COL_W + ROW_W;
    localparam int BC_W  = $clog2(BUSY_CYCLES + 1);

    ctl_state_e       state_q, state_d;
    out_src_e         src_q;
    logic [1:0]       acnt_q;
    logic [COL_W-1:0] col_q;
    logic [ROW_W-1:0] row_q;
    logic [MEM_W-1:0] aptr_q;
    logic [COL_W:0]   bptr_q;
    logic [1:0]       idx_q;
    logic [2:0]       left_q;
    logic             err_q;
    logic             wp_q;
    logic [BC_W-1:0]  busy_cnt_q;

    logic cmd_stb, adr_stb, dat_stb, rd_go;
    logic in_addr, cmd_ok, confirm, buf_room;
    logic [7:0] status_byte, id_byte;

    always_comb begin
        cmd_stb  = wr_stb && !ce_n && cle && !ale;
        adr_stb  = wr_stb && !ce_n && ale && !cle;
        dat_stb  = wr_stb && !ce_n && !cle && !ale;
        rd_go    = rd_stb && !ce_n && !wr_stb;
        in_addr  = (state_q == ST_RD_ADDR) || (state_q == ST_PG_ADDR) || (state_q == ST_ER_ADDR);
        cmd_ok   = cmd_stb && ((state_q != ST_BUSY) || (io_in == OP_STATUS));
        confirm  = cmd_ok && (((io_in == OP_PROG_GO) && (state_q == ST_PG_DATA)) ||
                              ((io_in == OP_ERASE_GO) && (state_q == ST_ER_ADDR)));
        buf_room = !bptr_q[COL_W];
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BUSY: begin
                if (busy_cnt_q == '0) state_d = ST_IDLE;
            end
            default: begin
                if (cmd_stb) begin
                    case (io_in)
                        OP_READ:                      state_d = ST_RD_ADDR;
                        OP_PROG:                      state_d = ST_PG_ADDR;
                        OP_ERASE:                     state_d = ST_ER_ADDR;
                        OP_ID, OP_STATUS, OP_RESET:   state_d = ST_IDLE;
                        OP_PROG_GO, OP_ERASE_GO: begin
                            if (confirm) state_d = wp_n ? ST_BUSY : ST_IDLE;
                        end
                        default: ;
                    endcase
                end else if (adr_stb && (acnt_q == 2'd2)) begin
                    if (state_q == ST_RD_ADDR) state_d = ST_RD_DATA;
                    if (state_q == ST_PG_ADDR) state_d = ST_PG_DATA;
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q      <= SRC_NONE;
            acnt_q     <= '0;
            col_q      <= '0;
            row_q      <= '0;
            aptr_q     <= '0;
            bptr_q     <= '0;
            idx_q      <= '0;
            left_q     <= '0;
            err_q      <= 1'b0;
            wp_q       <= 1'b1;
            busy_cnt_q <= '0;
        end else begin
            wp_q <= wp_n;
            if ((state_q == ST_BUSY) && (busy_cnt_q != '0))
                busy_cnt_q <= busy_cnt_q - BC_W'(1);
            if (cmd_ok) begin
                case (io_in)
                    OP_READ, OP_PROG, OP_ERASE: begin
                        src_q  <= SRC_NONE;
                        left_q <= '0;
                        acnt_q <= '0;
                        col_q  <= '0;
                        row_q  <= '0;
                        bptr_q <= '0;
                    end
                    OP_ID: begin
                        src_q  <= SRC_ID;
                        idx_q  <= '0;
                        left_q <= 3'd4;
                    end
                    OP_STATUS: begin
                        src_q  <= SRC_STAT;
                        left_q <= 3'd1;
                    end
                    OP_RESET: begin
                        src_q  <= SRC_NONE;
                        left_q <= '0;
                        idx_q  <= '0;
                        acnt_q <= '0;
                        col_q  <= '0;
                        row_q  <= '0;
                        aptr_q <= '0;
                        bptr_q <= '0;
                        err_q  <= 1'b0;
                    end
                    OP_PROG_GO, OP_ERASE_GO: begin
                        if (confirm) begin
                            if (wp_n) begin
                                src_q      <= SRC_NONE;
                                left_q     <= '0;
                                busy_cnt_q <= BC_W'(BUSY_CYCLES - 1);
                            end else begin
                                err_q <= 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end else if (adr_stb && in_addr && (acnt_q != 2'd3)) begin
                acnt_q <= acnt_q + 2'd1;
                if (acnt_q == 2'd0) begin
                    col_q <= io_in[COL_W-1:0];
                    if (state_q == ST_ER_ADDR) row_q <= io_in[ROW_W-1:0];
                end
                if ((acnt_q == 2'd1) && (state_q != ST_ER_ADDR))
                    row_q <= io_in[ROW_W-1:0];
                if ((acnt_q == 2'd2) && (state_q == ST_RD_ADDR)) begin
                    src_q  <= SRC_ARRAY;
                    aptr_q <= {row_q, col_q};
                end
            end else if (dat_stb && (state_q == ST_PG_DATA) && buf_room) begin
                bptr_q <= bptr_q + (COL_W + 1)'(1);
            end else if (rd_go) begin
                if (src_q == SRC_ARRAY) begin
                    aptr_q <= aptr_q + MEM_W'(1);
                end else if (left_q != '0) begin
                    left_q <= left_q - 3'd1;
                    idx_q  <= idx_q + 2'd1;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        status_byte = {wp_q, (state_q != ST_BUSY), 5'b00000, err_q};
        unique case (idx_q)
            2'd0: id_byte = MFR_CODE;
            2'd1: id_byte = DEV_CODE;
            2'd2: id_byte = ID_FILLER;
            2'd3: id_byte = ID_SMALLPAGE;
        endcase
        unique case (src_q)
            SRC_NONE:  io_out = 8'h00;
            SRC_ARRAY: io_out = rd_data;
            SRC_ID:    io_out = (left_q != '0) ? id_byte : 8'h00;
            SRC_STAT:  io_out = (left_q != '0) ? status_byte : 8'h00;
        endcase
        rb_n     = (state_q != ST_BUSY);
        rd_addr  = aptr_q;
        buf_clr  = cmd_ok && (io_in == OP_PROG);
        buf_we   = dat_stb && (state_q == ST_PG_DATA) && buf_room;
        buf_idx  = bptr_q[COL_W-1:0];
        buf_data = io_in;
        job_go   = confirm && wp_n;
        job_kind = (io_in == OP_ERASE_GO) ? JOB_ERASE : JOB_PROG;
        job_base = (io_in == OP_ERASE_GO)
                 ? {row_q[ROW_W-1:PB_W], {(PB_W + COL_W){1'b0}}}
                 : {row_q, {COL_W{1'b0}}};
    end

    // R7
    busy_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        job_go |=> !rb_n);

    // R9
    protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rb_n) |-> $past(wp_n));

    // R8
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rb_n && cmd_stb && (io_in != OP_STATUS)) |=> $stable(src_q));

    // R10
    soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_n && cmd_stb && (io_in == OP_RESET)) |=> (io_out == 8'h00 && !err_q && acnt_q == 2'd0));

    // R12
    wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_n && wr_stb && rd_stb && !ce_n && !cle && !ale &&
         (state_q != ST_PG_DATA) && (src_q != SRC_STAT)) |=> $stable(io_out));

endmodule

// File: rtl/nand_target.sv
module nand_target
    import nand_target_pkg::*;
#(
    parameter int         COL_W       = 4,
    parameter int         ROW_W       = 5,
    parameter int         PB_W        = 2,
    parameter int         BUSY_CYCLES = 80,
    parameter logic [7:0] MFR_CODE    = 8'hEC,
    parameter logic [7:0] DEV_CODE    = 8'h73
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce_n,
    input  logic       cle,
    input  logic       ale,
    input  logic       wp_n,
    input  logic       wr_stb,
    input  logic       rd_stb,
    input  logic [7:0] io_in,
    output logic [7:0] io_out,
    output logic       rb_n
);

    localparam int MEM_W = COL_W + ROW_W;

    logic             buf_clr, buf_we, job_go;
    logic [COL_W-1:0] buf_idx;
    logic [7:0]       buf_data, rd_data;
    job_e             job_kind;
    logic [MEM_W-1:0] job_base, rd_addr;

    nand_target_ctrl #(
        .COL_W(COL_W), .ROW_W(ROW_W), .PB_W(PB_W),
        .BUSY_CYCLES(BUSY_CYCLES), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
        .wp_n(wp_n), .wr_stb(wr_stb), .rd_stb(rd_stb), .io_in(io_in),
        .io_out(io_out), .rb_n(rb_n), .buf_clr(buf_clr), .buf_we(buf_we),
        .buf_idx(buf_idx), .buf_data(buf_data), .job_go(job_go),
        .job_kind(job_kind), .job_base(job_base), .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

    nand_target_store #(
        .COL_W(COL_W), .ROW_W(ROW_W), .PB_W(PB_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .buf_clr(buf_clr), .buf_we(buf_we),
        .buf_idx(buf_idx), .buf_data(buf_data), .job_go(job_go),
        .job_kind(job_kind), .job_base(job_base), .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

endmodule

// File: tb/nand_target_tb.sv
module nand_target_tb;

    localparam int CLK_PERIOD = 10;
    localparam int BUSY       = 80;
    localparam int NV         = 19;

    localparam logic [1:0] K_CMD = 2'd0, K_ADR = 2'd1, K_DAT = 2'd2, K_RDC = 2'd3;

    // {kind, value, expected, requirement number}
    localparam logic [21:0] VECS [NV] = '{
        {K_CMD, 8'h90, 8'h00, 4'd2},   // R2 identification
        {K_RDC, 8'h00, 8'hEC, 4'd2},
        {K_RDC, 8'h00, 8'h73, 4'd2},
        {K_RDC, 8'h00, 8'h5A, 4'd2},
        {K_RDC, 8'h00, 8'hC0, 4'd2},
        {K_RDC, 8'h00, 8'h00, 4'd2},
        {K_CMD, 8'h90, 8'h00, 4'd11},  // R11 unknown opcode
        {K_CMD, 8'h33, 8'h00, 4'd11},
        {K_RDC, 8'h00, 8'hEC, 4'd11},
        {K_CMD, 8'h10, 8'h00, 4'd11},  // R11 stray confirm
        {K_RDC, 8'h00, 8'h73, 4'd11},
        {K_CMD, 8'h70, 8'h00, 4'd3},   // R3 status
        {K_RDC, 8'h00, 8'hC0, 4'd3},
        {K_RDC, 8'h00, 8'h00, 4'd3},
        {K_CMD, 8'h00, 8'h00, 4'd4},   // R4 read erased array
        {K_ADR, 8'h0F, 8'h00, 4'd4},
        {K_ADR, 8'h03, 8'h00, 4'd4},
        {K_ADR, 8'h00, 8'h00, 4'd4},
        {K_RDC, 8'h00, 8'hFF, 4'd4}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce_n = 1'b0, cle = 1'b0, ale = 1'b0, wp_n = 1'b1;
    logic       wr_stb = 1'b0, rd_stb = 1'b0;
    logic [7:0] io_in = 8'h00;
    logic [7:0] io_out;
    logic       rb_n;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    nand_target u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
        .wp_n(wp_n), .wr_stb(wr_stb), .rd_stb(rd_stb), .io_in(io_in),
        .io_out(io_out), .rb_n(rb_n)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [1:0] k, input logic [7:0] v);
        @(negedge clk);
        cle = (k == K_CMD); ale = (k == K_ADR); io_in = v; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0; cle = 1'b0; ale = 1'b0;
    endtask

    task automatic pull(input string tag, input logic [7:0] exp);
        chk(tag, io_out, exp);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic addr3(input logic [7:0] col, input logic [7:0] row);
        put(K_ADR, col); put(K_ADR, row); put(K_ADR, 8'h00);
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (!rb_n && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic program1(input logic [7:0] row, input logic [7:0] d0);
        int n;
        put(K_CMD, 8'h80); addr3(8'h00, row); put(K_DAT, d0); put(K_CMD, 8'h10);
        wait_ready(n);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog: run did not complete (all requirements)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R13 reset state
        chk("R13 io_out after reset", io_out, 8'h00);
        chk("R13 rb_n after reset", {7'd0, rb_n}, 8'h01);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i][21:20] == K_RDC)
                pull($sformatf("R%0d vector %0d", VECS[i][3:0], i), VECS[i][11:4]);
            else
                put(VECS[i][21:20], VECS[i][19:12]);
        end

        // R5 / R7: program page 1, busy window length
        put(K_CMD, 8'h80); addr3(8'h00, 8'h01);
        put(K_DAT, 8'hA5); put(K_DAT, 8'h3C); put(K_CMD, 8'h10);
        wait_ready(n);
        chk("R7 busy cycles", 8'(n), 8'(BUSY));
        put(K_CMD, 8'h00); addr3(8'h00, 8'h01);
        pull("R5 page1 byte0", 8'hA5);
        pull("R5 page1 byte1", 8'h3C);
        pull("R5 page1 byte2", 8'hFF);

        // R5 AND merge; R7 status during busy; R8 command ignored while busy
        put(K_CMD, 8'h80); addr3(8'h00, 8'h01);
        put(K_DAT, 8'h0F); put(K_DAT, 8'hF0); put(K_CMD, 8'h10);
        put(K_CMD, 8'h70);
        chk("R7 status while busy", io_out, 8'h80);
        put(K_CMD, 8'h90);
        chk("R8 ID ignored while busy", io_out, 8'h80);
        wait_ready(n);
        put(K_CMD, 8'h00); addr3(8'h00, 8'h01);
        pull("R5 merged byte0", 8'h05);
        pull("R5 merged byte1", 8'h30);

        // R4 stream crosses page boundary
        program1(8'h02, 8'h77);
        put(K_CMD, 8'h00); addr3(8'h0F, 8'h01);
        pull("R4 last byte of page1", 8'hFF);
        pull("R4 first byte of page2", 8'h77);

        // R6 erase block 1 via row 5
        program1(8'h04, 8'h00);
        program1(8'h08, 8'h11);
        put(K_CMD, 8'h60); put(K_ADR, 8'h05); put(K_ADR, 8'h00); put(K_CMD, 8'hD0);
        wait_ready(n);
        put(K_CMD, 8'h00); addr3(8'h00, 8'h04);
        pull("R6 page4 erased", 8'hFF);
        put(K_CMD, 8'h00); addr3(8'h00, 8'h08);
        pull("R6 page8 kept", 8'h11);

        // R9 write protect
        wp_n = 1'b0;
        put(K_CMD, 8'h80); addr3(8'h00, 8'h06); put(K_DAT, 8'h00); put(K_CMD, 8'h10);
        chk("R9 no busy when protected", {7'd0, rb_n}, 8'h01);
        put(K_CMD, 8'h70);
        chk("R9 error in status", io_out, 8'h41);
        put(K_CMD, 8'h00); addr3(8'h00, 8'h06);
        pull("R9 array unchanged", 8'hFF);

        // R10 soft reset
        put(K_CMD, 8'hFF);
        chk("R10 io_out cleared", io_out, 8'h00);
        put(K_CMD, 8'h70);
        chk("R10 error cleared, bit7 kept", io_out, 8'h40);
        wp_n = 1'b1;
        @(negedge clk);
        put(K_CMD, 8'h70);
        chk("R3 status unprotected", io_out, 8'hC0);

        // R12 write and read in the same cycle
        put(K_CMD, 8'h90);
        @(negedge clk);
        io_in = 8'h55; wr_stb = 1'b1; rd_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0; rd_stb = 1'b0;
        chk("R12 read dropped on overlap", io_out, 8'hEC);
        pull("R12 lone read advances", 8'hEC);
        chk("R12 device code next", io_out, 8'h73);

        // R1 qualifiers
        ce_n = 1'b1;
        put(K_CMD, 8'h70);
        chk("R1 command ignored with ce_n high", io_out, 8'h73);
        rd_stb = 1'b1; @(negedge clk); rd_stb = 1'b0;
        chk("R1 read ignored with ce_n high", io_out, 8'h73);
        ce_n = 1'b0;
        @(negedge clk);
        cle = 1'b1; ale = 1'b1; io_in = 8'h70; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0; cle = 1'b0; ale = 1'b0;
        chk("R1 cle and ale both high ignored", io_out, 8'h73);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule